// File: doc/BRIEF.md
# Edge Change-Detection Interrupt Controller

This block watches a set of already-synchronized input lines, grouped into byte-wide ports, for level changes. Each line has two selection bits of its own, one for low-to-high changes and one for high-to-low changes. Each direction also has a global sense bit. A change counts only when the line's bit and the matching global bit are both set.

A counted change raises a sticky "change seen" flag. If another counted change arrives while that flag is still set, a second sticky "missed change" flag is raised as well. Either flag can drive one level-sensitive interrupt line. Each flag has its own source enable, and a master enable gates both. Software reads the flags and the interrupt level from a status byte. It drops each flag by writing a one to that flag's own bit in a write-only clear byte.

All configuration and status use a simple byte-wide register bus. Writes take effect on the clock edge. Reads are combinational from the registered state.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every per-line select byte, the control byte and both flags are zero, and `irq_o` is low.
- R2: Port p (0..3) has a low-to-high select byte at address 0x42+0x10·p and a high-to-low select byte at 0x43+0x10·p; bit b of a byte belongs to line 8·p+b. The control byte is at 0x03. All of these read back what was written, except that control bits 7:5 read as zero.
- R3: Control bit 3 enables low-to-high sensing and control bit 4 enables high-to-low sensing globally. A line change between two consecutive clock samples sets status bit 0 (address 0x02) on that clock edge only if both the line's select bit for that direction and the global bit are set.
- R4: Status bit 0 stays set, with no further changes, until it is cleared.
- R5: A counted change while status bit 0 is already set also sets status bit 1 (missed change). Bit 1 is also sticky.
- R6: Writing address 0x01 with bit 3 set clears status bit 0, and with bit 2 set clears status bit 1. Each bit acts independently, and the other bits of that write have no effect. Address 0x01 reads as zero.
- R7: When a clear write and a counted change fall in the same cycle, the change wins: status bit 0 ends set. Status bit 1 is set if bit 0 was already set before that cycle.
- R8: `irq_o` equals control bit 2 (master) AND ((bit 0 flag AND control bit 0) OR (bit 1 flag AND control bit 1)), and status bit 2 shows the same level. Writing 0x00 to the control byte lowers `irq_o` but keeps the flags.
- R9: A line held at a constant level, including one that was already high during reset, never produces a counted change, even after its selects are turned on.
- R10: Writes to addresses outside the mapped set change no state, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_i | input | 32 | Synchronized input lines, line 8·p+b on port p bit b |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request level |

## Verification
Two functions can land on the same clock edge: a flag-clear write and a new counted change. The bench provokes this by driving the clear write and the line transition on the same falling edge, so that both are sampled at the next rising edge. It then reads the status byte and expects the change flag set. It expects the missed-change flag set exactly when the change flag was already set beforehand. A near-exhaustive sweep over all 32 lines, both directions and all four combinations of line select and global sense checks every counted change against the AND rule computed in the bench.

// File: rtl/eic_pkg.sv
package eic_pkg;

    // Control byte layout; first field is the most significant bit.
    typedef struct packed {
        logic fall_sense;   // bit 4
        logic rise_sense;   // bit 3
        logic master;       // bit 2
        logic ovf_ie;       // bit 1
        logic edge_ie;      // bit 0
    } eic_ctl_t;

    localparam int OFS_CLEAR    = 'h01;
    localparam int OFS_STATUS   = 'h02;
    localparam int OFS_CTRL     = 'h03;
    localparam int CLR_EDGE_BIT = 3;
    localparam int CLR_OVF_BIT  = 2;
    localparam int RISE_SUBOFS  = 2;
    localparam int FALL_SUBOFS  = 3;

endpackage

// File: rtl/eic_port_det.sv
module eic_port_det #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] lines,
    input  logic [PORT_W-1:0] rise_en,
    input  logic [PORT_W-1:0] fall_en,
    input  logic              rise_on,
    input  logic              fall_on,
    output logic              hit
);

    logic [PORT_W-1:0] prev_d, prev_q;
    logic [PORT_W-1:0] up_hits, down_hits;

    always_comb begin
        prev_d    = lines;
        up_hits   = lines & ~prev_q & rise_en & {PORT_W{rise_on}};
        down_hits = ~lines & prev_q & fall_en & {PORT_W{fall_on}};
        hit       = |(up_hits | down_hits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R9: a counted change needs the lines to differ from last cycle
    a_r9_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (lines != $past(lines)));

endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int PORT_W      = 8,
    parameter int AW          = 8,
    parameter int PORT_BASE   = 'h40,
    parameter int PORT_STRIDE = 'h10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AW-1:0]                 addr,
    input  logic                          wr,
    input  logic [PORT_W-1:0]             wdata,
    output logic [PORT_W-1:0]             rdata,
    input  logic                          edge_flag,
    input  logic                          ovf_flag,
    input  logic                          irq,
    output logic [NPORTS-1:0][PORT_W-1:0] rise_en,
    output logic [NPORTS-1:0][PORT_W-1:0] fall_en,
    output eic_ctl_t                      ctl,
    output logic                          clr_edge,
    output logic                          clr_ovf
);

    localparam int CTL_W = $bits(eic_ctl_t);

    typedef struct packed {
        logic [NPORTS-1:0][PORT_W-1:0] rise;
        logic [NPORTS-1:0][PORT_W-1:0] fall;
        eic_ctl_t                      ctl;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPORTS-1:0] sel_rise, sel_fall;
    logic sel_clear, sel_status, sel_ctrl, any_sel;

    for (genvar p = 0; p < NPORTS; p++) begin : g_dec
        localparam int RISE_ADDR = PORT_BASE + PORT_STRIDE * p + RISE_SUBOFS;
        localparam int FALL_ADDR = PORT_BASE + PORT_STRIDE * p + FALL_SUBOFS;
        assign sel_rise[p] = (addr == AW'(RISE_ADDR));
        assign sel_fall[p] = (addr == AW'(FALL_ADDR));
    end

    assign sel_clear  = (addr == AW'(OFS_CLEAR));
    assign sel_status = (addr == AW'(OFS_STATUS));
    assign sel_ctrl   = (addr == AW'(OFS_CTRL));
    assign any_sel    = sel_clear | sel_status | sel_ctrl | (|sel_rise) | (|sel_fall);

    always_comb begin
        r_d = r_q;
        if (wr) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (sel_rise[p]) r_d.rise[p] = wdata;
                if (sel_fall[p]) r_d.fall[p] = wdata;
            end
            if (sel_ctrl) r_d.ctl = eic_ctl_t'(wdata[CTL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clr_edge = wr && sel_clear && wdata[CLR_EDGE_BIT];
    assign clr_ovf  = wr && sel_clear && wdata[CLR_OVF_BIT];
    assign rise_en  = r_q.rise;
    assign fall_en  = r_q.fall;
    assign ctl      = r_q.ctl;

    always_comb begin
        rdata = '0;
        if (sel_status) rdata[2:0] = {irq, ovf_flag, edge_flag};
        if (sel_ctrl)   rdata[CTL_W-1:0] = r_q.ctl;
        for (int p = 0; p < NPORTS; p++) begin
            if (sel_rise[p]) rdata = r_q.rise[p];
            if (sel_fall[p]) rdata = r_q.fall[p];
        end
    end

    // R2: configuration only moves on a write
    a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctl));
    // R10: writes to unmapped addresses leave all state alone
    a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !any_sel) |=> ($stable(rise_en) && $stable(fall_en) && $stable(ctl)));

endmodule

// File: rtl/eic_flags.sv
module eic_flags
    import eic_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_hit,
    input  logic              clr_edge,
    input  logic              clr_ovf,
    input  eic_ctl_t          ctl,
    output logic              edge_flag,
    output logic              ovf_flag,
    output logic              irq
);

    typedef struct packed {
        logic edge_f;
        logic ovf_f;
    } flags_t;

    flags_t f_d, f_q;
    logic any_hit;

    always_comb begin
        any_hit = |port_hit;
        f_d     = f_q;
        if (any_hit)       f_d.edge_f = 1'b1;
        else if (clr_edge) f_d.edge_f = 1'b0;
        if (any_hit && f_q.edge_f) f_d.ovf_f = 1'b1;
        else if (clr_ovf)          f_d.ovf_f = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign edge_flag = f_q.edge_f;
    assign ovf_flag  = f_q.ovf_f;
    assign irq = ctl.master & ((f_q.edge_f & ctl.edge_ie) | (f_q.ovf_f & ctl.ovf_ie));

    // R4: change flag is sticky without a clear
    a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_flag && !clr_edge) |=> edge_flag);
    // R7: a counted change always leaves the change flag set, clear or not
    a_r7_change_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> edge_flag);
    // R5: change on a pending flag raises the missed-change flag
    a_r5_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && edge_flag) |=> ovf_flag);
    // R5: missed-change flag never rises without a pending change flag
    a_r5_overflow_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(edge_flag));
    // R6: clear drops the missed-change flag unless R7 applies
    a_r6_ovf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !(any_hit && edge_flag)) |=> !ovf_flag);
    // R8: no interrupt without the master enable
    a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.master |-> !irq);

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int PORT_W      = 8,
    parameter int AW          = 8,
    parameter int PORT_BASE   = 'h40,
    parameter int PORT_STRIDE = 'h10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS*PORT_W-1:0] lines_i,
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_wr,
    input  logic [PORT_W-1:0]        bus_wdata,
    output logic [PORT_W-1:0]        bus_rdata,
    output logic                     irq_o
);

    logic [NPORTS-1:0][PORT_W-1:0] rise_en, fall_en;
    logic [NPORTS-1:0]             port_hit;
    eic_ctl_t                      ctl;
    logic clr_edge, clr_ovf, edge_flag, ovf_flag, irq;

    eic_regs #(
        .NPORTS(NPORTS), .PORT_W(PORT_W), .AW(AW),
        .PORT_BASE(PORT_BASE), .PORT_STRIDE(PORT_STRIDE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata), .rdata(bus_rdata),
        .edge_flag(edge_flag), .ovf_flag(ovf_flag), .irq(irq),
        .rise_en(rise_en), .fall_en(fall_en), .ctl(ctl),
        .clr_edge(clr_edge), .clr_ovf(clr_ovf)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        eic_port_det #(.PORT_W(PORT_W)) u_det (
            .clk(clk), .rst_n(rst_n),
            .lines(lines_i[p*PORT_W +: PORT_W]),
            .rise_en(rise_en[p]), .fall_en(fall_en[p]),
            .rise_on(ctl.rise_sense), .fall_on(ctl.fall_sense),
            .hit(port_hit[p])
        );
    end

    eic_flags #(.NPORTS(NPORTS)) u_flags (
        .clk(clk), .rst_n(rst_n), .port_hit(port_hit),
        .clr_edge(clr_edge), .clr_ovf(clr_ovf), .ctl(ctl),
        .edge_flag(edge_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    assign irq_o = irq;

endmodule

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lines;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        irq;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    edge_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lines_i(lines),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called right after a falling edge; returns right after the next one.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Write and line change sampled on the same rising edge.
    task automatic wr_lines(input logic [7:0] a, input logic [7:0] d, input logic [31:0] v);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; lines = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_lines(input logic [31:0] v);
        lines = v;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    logic [7:0] v;

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        lines = 32'h0000_0100;           // line 8 high through reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h02, v); chk("R1 status", v, 8'h00);
        rd(8'h03, v); chk("R1 ctrl", v, 8'h00);
        rd(8'h42, v); chk("R1 rise sel p0", v, 8'h00);
        rd(8'h73, v); chk("R1 fall sel p3", v, 8'h00);
        chk("R1 irq", irq, 0);

        // R9 steady high level from reset never counts
        wr(8'h52, 8'hFF);
        wr(8'h03, 8'h1F);
        repeat (3) @(negedge clk);
        rd(8'h02, v); chk("R9 steady level", v, 8'h00);
        wr(8'h03, 8'h00);
        set_lines(32'h0);
        wr(8'h52, 8'h00);

        // R2 readback of every select byte and control
        for (int p = 0; p < 4; p++) begin
            wr(8'(8'h42 + 16*p), 8'(8'h11 * (p + 1)));
            wr(8'(8'h43 + 16*p), 8'(8'hA0 + p));
        end
        for (int p = 0; p < 4; p++) begin
            rd(8'(8'h42 + 16*p), v); chk("R2 rise sel", v, 8'(8'h11 * (p + 1)));
            rd(8'(8'h43 + 16*p), v); chk("R2 fall sel", v, 8'(8'hA0 + p));
        end
        wr(8'h03, 8'hFF);
        rd(8'h03, v); chk("R2 ctrl upper bits", v, 8'h1F);
        wr(8'h03, 8'h00);
        for (int p = 0; p < 4; p++) begin
            wr(8'(8'h42 + 16*p), 8'h00);
            wr(8'(8'h43 + 16*p), 8'h00);
        end

        // R10 unmapped writes
        wr(8'h82, 8'hFF); wr(8'h44, 8'hFF); wr(8'h00, 8'hFF); wr(8'h41, 8'hFF);
        rd(8'h82, v); chk("R10 unmapped read", v, 8'h00);
        rd(8'h44, v); chk("R10 unmapped read", v, 8'h00);
        rd(8'h42, v); chk("R10 sel untouched", v, 8'h00);
        rd(8'h53, v); chk("R10 sel untouched", v, 8'h00);
        rd(8'h03, v); chk("R10 ctrl untouched", v, 8'h00);
        rd(8'h01, v); chk("R6 clear reads zero", v, 8'h00);

        // R3 sweep: every line, both directions, line select x global sense
        for (int k = 0; k < 32; k++) begin
            for (int per = 0; per < 2; per++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [7:0] sel;
                    logic [7:0] exp_st;
                    logic [7:0] a_r, a_f;
                    a_r = 8'(8'h42 + 16*(k/8));
                    a_f = 8'(8'h43 + 16*(k/8));
                    sel = per ? 8'(1 << (k%8)) : ~8'(1 << (k%8));
                    exp_st = (per && g) ? 8'h05 : 8'h00;
                    // low-to-high
                    wr(a_r, sel);
                    wr(8'h03, g ? 8'h0D : 8'h05);
                    wr(8'h01, 8'h0C);
                    set_lines(32'(1) << k);
                    rd(8'h02, v); chk("R3 rise sweep", v, exp_st);
                    chk("R8 irq rise sweep", irq, exp_st[2]);
                    wr(8'h03, 8'h00);
                    wr(a_r, 8'h00);
                    // high-to-low, line already high
                    wr(a_f, sel);
                    wr(8'h03, g ? 8'h15 : 8'h05);
                    wr(8'h01, 8'h0C);
                    set_lines(32'h0);
                    rd(8'h02, v); chk("R3 fall sweep", v, exp_st);
                    wr(8'h03, 8'h00);
                    wr(a_f, 8'h00);
                end
            end
        end
        wr(8'h01, 8'h0C);

        // R4 / R5 / R6 directed on line 0
        wr(8'h42, 8'h01); wr(8'h43, 8'h01); wr(8'h03, 8'h1F);
        set_lines(32'h1);
        rd(8'h02, v); chk("R3 directed", v, 8'h05);
        repeat (3) @(negedge clk);
        rd(8'h02, v); chk("R4 sticky", v, 8'h05);
        set_lines(32'h0);
        rd(8'h02, v); chk("R5 overflow", v, 8'h07);
        repeat (2) @(negedge clk);
        rd(8'h02, v); chk("R5 overflow sticky", v, 8'h07);
        wr(8'h01, 8'h08);
        rd(8'h02, v); chk("R6 clear change only", v, 8'h06);
        wr(8'h01, 8'h04);
        rd(8'h02, v); chk("R6 clear overflow", v, 8'h00);
        chk("R8 irq low after clear", irq, 0);
        set_lines(32'h1);
        wr(8'h01, 8'hF3);
        rd(8'h02, v); chk("R6 other clear bits", v, 8'h05);

        // R8 gating
        wr(8'h03, 8'h1E);
        rd(8'h02, v); chk("R8 change ie off", v, 8'h01);
        chk("R8 irq change ie off", irq, 0);
        wr(8'h03, 8'h1B);
        chk("R8 irq master off", irq, 0);
        wr(8'h03, 8'h00);
        rd(8'h02, v); chk("R8 ctrl zero keeps flags", v, 8'h01);
        chk("R8 irq ctrl zero", irq, 0);
        wr(8'h03, 8'h1F);
        chk("R8 irq restored", irq, 1);

        // R7 clear and change in the same cycle, flag already set
        wr_lines(8'h01, 8'h0C, 32'h0);
        rd(8'h02, v); chk("R7 change wins pending", v, 8'h07);
        wr(8'h01, 8'h0C);
        rd(8'h02, v); chk("R7 cleared", v, 8'h00);
        // R7 with flag clear beforehand: no missed change
        wr_lines(8'h01, 8'h0C, 32'h1);
        rd(8'h02, v); chk("R7 change wins fresh", v, 8'h05);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule